// File: doc/BRIEF.md
# Dual-Product Accumulator with Rounding and Cascade

This block is a fully pipelined arithmetic core. Each clock it takes two pairs of signed operands, multiplies each pair, and can negate either product on its own. It adds the two products together, can inject a half-LSB rounding constant, and can add a 16-bit cascade word aligned to the upper bits. The result either starts a fresh running sum or is added to the sum already held in a 24-bit accumulator.

It is used as a tile in mixing, modulation, complex-multiply and filter datapaths. Each control travels down the pipeline next to the operands it arrived with, so a new operation can be issued every clock. A feedthrough control shortens the cascade path, which lets the output of one tile feed the cascade port of the next with little added delay.

Top module: `dual_product_acc`

## Requirements
- R1: `op_a`/`op_b` and `op_c`/`op_d` are 12-bit two's-complement pairs. Each 24-bit signed product is sign-extended, and the two products are added.
- R2: When `neg_ab` is 1, the product `op_a*op_b` is subtracted instead of added.
- R3: When `neg_cd` is 1, the product `op_c*op_d` is subtracted instead of added, independently of `neg_ab`.
- R4: When `acc_keep` is 0, the accumulator is loaded with the new term and the old sum is discarded. When it is 1, the new term is added to the running sum.
- R5: When `rnd_req` is 1 and `acc_keep` is 0, the value 128 (bit 7) is added to the term. When `acc_keep` is 1, `rnd_req` has no effect.
- R6: When `cas_use_n` is 0, `cas_in` is treated as signed and added at bits 23..8 (value `cas_in*256`). When `cas_use_n` is 1, the cascade word contributes nothing.
- R7: Operands and controls sampled at rising edge n give a result on `acc_out` that becomes visible at edge n+5, so the latency is six clocks including the sampling edge.
- R8: A cascade word sampled with `cas_bypass` = 1 at edge m joins the products sampled at edge m-3. A word sampled with `cas_bypass` = 0 joins the products sampled on its own edge. A word sampled with bypass is added only once.
- R9: The accumulator wraps modulo 2^24 and does not saturate.
- R10: A synchronous active-high `rst` sets `acc_out` and every pipeline stage to zero on the next edge.
- R11: The negate, round and accumulate controls act on the operands sampled on the same edge, even when the controls change every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 12 | First operand of product one (signed) |
| op_b | input | 12 | Second operand of product one (signed) |
| op_c | input | 12 | First operand of product two (signed) |
| op_d | input | 12 | Second operand of product two (signed) |
| neg_ab | input | 1 | Subtract product one |
| neg_cd | input | 1 | Subtract product two |
| acc_keep | input | 1 | 1: add to running sum, 0: start fresh sum |
| rnd_req | input | 1 | Inject rounding constant at bit 7 on a fresh sum |
| cas_in | input | 16 | Signed cascade word, weighted at bits 23..8 |
| cas_use_n | input | 1 | Active-low cascade enable |
| cas_bypass | input | 1 | Short cascade path (three fewer stages) |
| acc_out | output | 24 | Accumulator value |

## Verification
A wrong sign in one product lane, or a wrong negate, round or accumulate bit, shows up on `acc_out` exactly six clocks after the operands that carry it. Because the accumulator feeds itself, a corrupted sum persists on every later output until a cycle with `acc_keep` low clears it. A cascade word aligned to the wrong stage is added to the result of a neighbouring operand set. This shifts the output by a multiple of 256 in a cycle that the accumulate chain exposes. The bench therefore compares every output cycle against a reference sum built from the requirements, using per-cycle control changes and a chain that uses the bypassed cascade path.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int DEF_OPW     = 12;
    localparam int DEF_CASW    = 16;
    localparam int DEF_CAS_LAG = 3;

    // control bits that ride with the operands down to the sum stages
    typedef struct packed {
        logic keep;
        logic rnd;
    } sum_ctrl_t;

    // rounding addend: one at the bit just below the upper word, only on a fresh sum
    function automatic logic [63:0] round_addend(input logic rnd, input logic keep,
                                                 input int unsigned bitpos);
        round_addend = (rnd && !keep) ? (64'd1 << bitpos) : 64'd0;
    endfunction

endpackage

// File: rtl/dpa_pipe.sv
module dpa_pipe #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/dpa_lane.sv
// One product lane: capture (S1), multiply (S2), optional negate with sign extension (S3).
module dpa_lane #(
    parameter int OPW = 12,
    parameter int AW  = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [OPW-1:0] x,
    input  logic signed [OPW-1:0] y,
    input  logic                  neg,
    output logic signed [AW-1:0]  term
);
    localparam int PW = 2 * OPW;

    logic signed [OPW-1:0] x_q, y_q;
    logic                  neg_s1, neg_s2;
    logic signed [PW-1:0]  prod_q;
    logic signed [AW-1:0]  prod_ext;
    logic signed [AW-1:0]  term_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            neg_s1 <= 1'b0;
        end else begin
            x_q    <= x;
            y_q    <= y;
            neg_s1 <= neg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            neg_s2 <= 1'b0;
        end else begin
            prod_q <= x_q * y_q;
            neg_s2 <= neg_s1;
        end
    end

    assign prod_ext = AW'(prod_q);

    always_ff @(posedge clk) begin
        if (rst) term_q <= '0;
        else     term_q <= neg_s2 ? -prod_ext : prod_ext;
    end

    assign term = term_q;

    // R1: product sign follows operand signs
    a_r1_product_sign: assert property (@(posedge clk) disable iff (rst)
        (x_q != '0 && y_q != '0) |=> prod_q[PW-1] == $past(x_q[OPW-1] ^ y_q[OPW-1]));

    // R2/R3: a negated nonzero product leaves the lane with the opposite sign
    a_r2_negate_flips_sign: assert property (@(posedge clk) disable iff (rst)
        (neg_s2 && prod_q != '0) |=> term_q[AW-1] != $past(prod_q[PW-1]));
endmodule

// File: rtl/dpa_cascade.sv
// Cascade path: capture, then either use at once (bypass) or after LAG extra stages.
module dpa_cascade #(
    parameter int CASW = 16,
    parameter int AW   = 24,
    parameter int LAG  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CASW-1:0]      cas,
    input  logic                 use_n,
    input  logic                 bypass,
    output logic signed [AW-1:0] cas_term
);
    localparam int SH = AW - CASW;

    logic [CASW-1:0] cas_q;
    logic            use_q, byp_q;
    logic [CASW-1:0] cas_d;
    logic            use_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_q <= '0;
            use_q <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            cas_q <= cas;
            use_q <= !use_n;
            byp_q <= bypass;
        end
    end

    // a word that took the short path is not offered again by the long one
    dpa_pipe #(.W(CASW + 1), .DEPTH(LAG)) u_lag (
        .clk (clk),
        .rst (rst),
        .d   ({use_q & ~byp_q, cas_q}),
        .q   ({use_d, cas_d})
    );

    always_comb begin
        if (byp_q) cas_term = use_q ? {cas_q, {SH{1'b0}}} : '0;
        else       cas_term = use_d ? {cas_d, {SH{1'b0}}} : '0;
    end
endmodule

// File: rtl/dpa_sum_accum.sv
// S4: add lanes plus round; S5: accumulate with cascade; S6: output register.
module dpa_sum_accum
    import dpa_pkg::*;
#(
    parameter int AW      = 24,
    parameter int RND_BIT = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 keep,
    input  logic                 rnd,
    input  logic signed [AW-1:0] t0,
    input  logic signed [AW-1:0] t1,
    input  logic signed [AW-1:0] cas_term,
    output logic [AW-1:0]        acc_out
);
    sum_ctrl_t        ctl_in, ctl_s3;
    logic [AW-1:0]    rnd_add;
    logic [AW-1:0]    sum_q;
    logic             keep_s4;
    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    out_q;

    assign ctl_in = '{keep: keep, rnd: rnd};

    // controls travel three stages to meet the lane outputs
    dpa_pipe #(.W($bits(sum_ctrl_t)), .DEPTH(3)) u_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_in),
        .q   (ctl_s3)
    );

    assign rnd_add = AW'(round_addend(ctl_s3.rnd, ctl_s3.keep, RND_BIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            keep_s4 <= 1'b0;
        end else begin
            sum_q   <= t0 + t1 + rnd_add;
            keep_s4 <= ctl_s3.keep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (keep_s4) acc_q <= acc_q + sum_q + cas_term;
        else              acc_q <= sum_q + cas_term;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= acc_q;
    end

    assign acc_out = out_q;

    // R5: rounding never disturbs the bits below the round position
    a_r5_round_leaves_low_bits: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sum_q[RND_BIT-1:0] == RND_BIT'($past(t0) + $past(t1)));

    // R4: keeping with an all-zero term holds the running sum
    a_r4_keep_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (keep_s4 && sum_q == '0 && cas_term == '0) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/dual_product_acc.sv
module dual_product_acc
    import dpa_pkg::*;
#(
    parameter int OPW     = DEF_OPW,
    parameter int CASW    = DEF_CASW,
    parameter int CAS_LAG = DEF_CAS_LAG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    input  logic [OPW-1:0]  op_c,
    input  logic [OPW-1:0]  op_d,
    input  logic            neg_ab,
    input  logic            neg_cd,
    input  logic            acc_keep,
    input  logic            rnd_req,
    input  logic [CASW-1:0] cas_in,
    input  logic            cas_use_n,
    input  logic            cas_bypass,
    output logic [2*OPW-1:0] acc_out
);
    localparam int AW      = 2 * OPW;
    localparam int SH      = AW - CASW;
    localparam int RND_BIT = SH - 1;
    localparam int NLANE   = 2;

    logic signed [OPW-1:0] lhs [NLANE];
    logic signed [OPW-1:0] rhs [NLANE];
    logic                  ngt [NLANE];
    logic signed [AW-1:0]  lane_term [NLANE];
    logic signed [AW-1:0]  cas_term;

    assign lhs[0] = op_a;
    assign rhs[0] = op_b;
    assign ngt[0] = neg_ab;
    assign lhs[1] = op_c;
    assign rhs[1] = op_d;
    assign ngt[1] = neg_cd;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        dpa_lane #(.OPW(OPW), .AW(AW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .x    (lhs[i]),
            .y    (rhs[i]),
            .neg  (ngt[i]),
            .term (lane_term[i])
        );
    end

    dpa_cascade #(.CASW(CASW), .AW(AW), .LAG(CAS_LAG)) u_cas (
        .clk      (clk),
        .rst      (rst),
        .cas      (cas_in),
        .use_n    (cas_use_n),
        .bypass   (cas_bypass),
        .cas_term (cas_term)
    );

    dpa_sum_accum #(.AW(AW), .RND_BIT(RND_BIT)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .keep     (acc_keep),
        .rnd      (rnd_req),
        .t0       (lane_term[0]),
        .t1       (lane_term[1]),
        .cas_term (cas_term),
        .acc_out  (acc_out)
    );

    // R10: reset clears the output on the next edge
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> acc_out == '0);

    // R6: the cascade term never carries bits below its weight
    a_r6_cascade_weight: assert property (@(posedge clk) disable iff (rst)
        cas_term[SH-1:0] == '0);
endmodule

// File: tb/dual_product_acc_tb.sv
module dual_product_acc_tb;
    localparam int NV = 17;
    localparam int NT = NV + 8;
    localparam time CLK_P = 20ns;

    // {a,b,c,d, neg_ab,neg_cd,keep,rnd,use_n,bypass, cas}
    localparam logic [69:0] VEC [NV] = '{
        {12'h003,12'h004,12'h005,12'h006, 6'b000010, 16'h0000},
        {12'hFF9,12'h009,12'h064,12'hFFD, 6'b000010, 16'h0000},
        {12'h032,12'h014,12'h00A,12'h00A, 6'b100010, 16'h0000},
        {12'h032,12'h014,12'h00A,12'h00A, 6'b010010, 16'h0000},
        {12'h3E8,12'h3E8,12'h000,12'h000, 6'b000110, 16'h0000},
        {12'h001,12'h001,12'h001,12'h001, 6'b001110, 16'h0000},
        {12'h002,12'h003,12'h000,12'h000, 6'b001010, 16'h0000},
        {12'h005,12'h005,12'h000,12'h000, 6'b000000, 16'h0102},
        {12'h001,12'h001,12'h000,12'h000, 6'b000010, 16'h7FFF},
        {12'h000,12'h000,12'h000,12'h000, 6'b000000, 16'hFFFE},
        {12'h800,12'h800,12'h800,12'h800, 6'b000010, 16'h0000},
        {12'h800,12'h800,12'h800,12'h800, 6'b001010, 16'h0000},
        {12'h007,12'h007,12'hFFF,12'h001, 6'b110110, 16'h0000},
        {12'h00A,12'h00A,12'h000,12'h000, 6'b000010, 16'h0000},
        {12'h000,12'h000,12'h000,12'h000, 6'b001010, 16'h0000},
        {12'h000,12'h000,12'h000,12'h000, 6'b001010, 16'h0000},
        {12'h000,12'h000,12'h000,12'h000, 6'b001001, 16'h0040}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] op_a = 0, op_b = 0, op_c = 0, op_d = 0;
    logic        neg_ab = 0, neg_cd = 0, acc_keep = 0, rnd_req = 0;
    logic [15:0] cas_in = 0;
    logic        cas_use_n = 1, cas_bypass = 0;
    logic [23:0] acc_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [23:0] expv [NT];

    always #(CLK_P/2) clk = ~clk;

    dual_product_acc u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .neg_ab(neg_ab), .neg_cd(neg_cd), .acc_keep(acc_keep), .rnd_req(rnd_req),
        .cas_in(cas_in), .cas_use_n(cas_use_n), .cas_bypass(cas_bypass), .acc_out(acc_out)
    );

    function automatic logic [69:0] vec_at(int k);
        return (k >= 0 && k < NV) ? VEC[k] : {54'h0, 16'h0} | 70'h10000;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4, 5:    return "R5";
            6:       return "R4";
            7, 8, 9: return "R6";
            10, 11:  return "R9";
            12:      return "R11";
            13, 14, 15, 16: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: acc_out=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic drive(logic [69:0] v);
        {op_a, op_b, op_c, op_d} = v[69:22];
        {neg_ab, neg_cd, acc_keep, rnd_req, cas_use_n, cas_bypass} = v[21:16];
        cas_in = v[15:0];
    endtask

    // reference model built from the requirements
    task automatic build_model();
        logic [23:0] run = '0;
        for (int k = 0; k < NT; k++) begin
            logic [69:0] v = vec_at(k);
            logic [69:0] w = vec_at(k + 3);
            int p1, p2, t, cv;
            p1 = int'($signed(v[69:58])) * int'($signed(v[57:46]));
            p2 = int'($signed(v[45:34])) * int'($signed(v[33:22]));
            if (v[21]) p1 = -p1;
            if (v[20]) p2 = -p2;
            t = p1 + p2;
            if (v[18] && !v[19]) t += 128;
            cv = 0;
            if (w[16] && !w[17])      cv = int'($signed(w[15:0])) * 256;
            else if (!v[16] && !v[17]) cv = int'($signed(v[15:0])) * 256;
            run = v[19] ? run + 24'(t + cv) : 24'(t + cv);
            expv[k] = run;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: acc_out=%h expected=done", acc_out);
        finish_run();
    end

    initial begin
        build_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", acc_out, 24'h0);
        rst = 0;
        // table walk: output for vector k is sampled six negedges after it is driven
        for (int t = 0; t < NT + 6; t++) begin
            if (t >= 6) check(tag_of(t - 6), acc_out, expv[t - 6]);
            drive(vec_at(t));
            @(negedge clk);
        end

        // directed: mid-run reset discards a running sum (R10)
        drive({12'd100, 12'd100, 12'd0, 12'd0, 6'b000010, 16'h0});
        @(negedge clk);
        drive({12'd100, 12'd100, 12'd0, 12'd0, 6'b001010, 16'h0});
        repeat (6) @(negedge clk);
        check("R4", acc_out, 24'd20000);
        rst = 1;
        @(negedge clk);
        check("R10", acc_out, 24'h0);
        rst = 0;
        drive(vec_at(-1));
        repeat (7) @(negedge clk);
        check("R10", acc_out, 24'h0);

        // directed: cascade disabled has no effect on a keep chain (R6)
        drive({12'd3, 12'd3, 12'd0, 12'd0, 6'b000010, 16'h1234});
        @(negedge clk);
        drive({12'd0, 12'd0, 12'd0, 12'd0, 6'b001010, 16'h5555});
        repeat (6) @(negedge clk);
        check("R6", acc_out, 24'd9);
        @(negedge clk);
        check("R6", acc_out, 24'd9);
        finish_run();
    end
endmodule